// File: doc/BRIEF.md
# Sequence Timing Counter with Direct and Registered Clear/Hold

This block is a small binary up-counter that acts as the time base of a programmable sequence generator. The count advances by one on every active clock edge unless a clear or a hold is requested. Surrounding logic uses the count to pace waveforms and to time the wait states of state machines.

Clear and hold each arrive by two routes. A direct request comes straight from the combinational control logic and takes effect on the same active edge. A registered request lives in a set/reset flag that updates on the active edge, so it acts on the edge after the one that set it. When a clear and a hold are both pending, the clear wins. A static configuration input selects whether the counter runs on the rising or the falling edge of the clock.

Top module: `seq_counter`

## Requirements
- R1: While rst_ni is low, count_o, clr_reg_o and hold_reg_o are all 0.
- R2: With no clear and no hold request pending, count_o increases by one on each active edge.
- R3: From the all-ones value (63 for the default 6-bit width) the next count is 0.
- R4: If clr_dir_i is high, or clr_reg_o is 1, at an active edge, count_o is 0 after that edge.
- R5: If hold_dir_i is high or hold_reg_o is 1, and no clear is pending, count_o keeps its value across the active edge.
- R6: A clear request overrides a hold request that is pending at the same edge.
- R7: At each active edge a registered flag (clr_reg_o from clr_set_i/clr_rst_i, hold_reg_o from hold_set_i/hold_rst_i) becomes 0 if its reset input is high, becomes 1 if only its set input is high, and keeps its value if both are low. If both inputs are high, reset wins and the flag becomes 0.
- R8: A registered flag affects the counter on the first active edge after the edge that set it. A direct request acts on the edge at which it is sampled.
- R9: With neg_edge_i = 0 all state changes on rising edges of clk_i. With neg_edge_i = 1 all state changes on falling edges. Nothing changes on the other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low initialization reset |
| neg_edge_i | input | 1 | Edge select: 0 = rising edge, 1 = falling edge (static) |
| clr_dir_i | input | 1 | Direct synchronous-clear request |
| hold_dir_i | input | 1 | Direct count-hold request |
| clr_set_i | input | 1 | Set term of the registered clear flag |
| clr_rst_i | input | 1 | Reset term of the registered clear flag |
| hold_set_i | input | 1 | Set term of the registered hold flag |
| hold_rst_i | input | 1 | Reset term of the registered hold flag |
| count_o | output | CNT_W (6) | Current count |
| clr_reg_o | output | 1 | Registered clear flag |
| hold_reg_o | output | 1 | Registered hold flag |

## Verification
The assertions check on every active edge how the count responds to the pending clear, hold or idle condition. This covers increment with wrap, clear priority over hold, and holding. They also check the set, reset, keep and reset-dominant update of both flags. Only the bench scenarios can show the one-edge latency of a registered flag against a direct request, and that nothing moves on the inactive clock edge in either polarity. They also show the reset values, checked while reset is held across a change of edge polarity.

// File: rtl/seq_cnt_pkg.sv
package seq_cnt_pkg;
  typedef struct packed {
    logic clr;
    logic hold;
  } cnt_ctrl_t;

  localparam int unsigned NUM_REG_CTRL = 2;
  localparam int unsigned IDX_CLR      = 0;
  localparam int unsigned IDX_HOLD     = 1;
endpackage

// File: rtl/seq_edge_sel.sv
module seq_edge_sel (
  input  logic clk_i,
  input  logic neg_edge_i,
  output logic clk_o
);
  // static select: invert clock so the falling edge becomes the active rising edge
  assign clk_o = clk_i ^ neg_edge_i;
endmodule

// File: rtl/seq_sr_bit.sv
module seq_sr_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rst_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (rst_i)  q_q <= 1'b0;   // reset dominant when both high
    else if (set_i)  q_q <= 1'b1;
  end

  assign q_o = q_q;
endmodule

// File: rtl/seq_cnt_core.sv
module seq_cnt_core
  import seq_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_ctrl_t        dir_i,
  input  cnt_ctrl_t        reg_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             clr_any;
  logic             hold_any;

  assign clr_any  = dir_i.clr  | reg_i.clr;
  assign hold_any = dir_i.hold | reg_i.hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_any)   cnt_q <= '0;
    else if (!hold_any) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/seq_counter.sv
module seq_counter
  import seq_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             neg_edge_i,
  input  logic             clr_dir_i,
  input  logic             hold_dir_i,
  input  logic             clr_set_i,
  input  logic             clr_rst_i,
  input  logic             hold_set_i,
  input  logic             hold_rst_i,
  output logic [CNT_W-1:0] count_o,
  output logic             clr_reg_o,
  output logic             hold_reg_o
);
  logic                    clk_act;
  logic [NUM_REG_CTRL-1:0] set_v;
  logic [NUM_REG_CTRL-1:0] rst_v;
  logic [NUM_REG_CTRL-1:0] flag_v;
  cnt_ctrl_t               dir_ctrl;
  cnt_ctrl_t               reg_ctrl;

  seq_edge_sel u_edge (
    .clk_i      (clk_i),
    .neg_edge_i (neg_edge_i),
    .clk_o      (clk_act)
  );

  assign set_v[IDX_CLR]  = clr_set_i;
  assign rst_v[IDX_CLR]  = clr_rst_i;
  assign set_v[IDX_HOLD] = hold_set_i;
  assign rst_v[IDX_HOLD] = hold_rst_i;

  for (genvar g = 0; g < NUM_REG_CTRL; g++) begin : g_flag
    seq_sr_bit u_flag (
      .clk_i  (clk_act),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .rst_i  (rst_v[g]),
      .q_o    (flag_v[g])
    );
  end

  assign dir_ctrl.clr  = clr_dir_i;
  assign dir_ctrl.hold = hold_dir_i;
  assign reg_ctrl.clr  = flag_v[IDX_CLR];
  assign reg_ctrl.hold = flag_v[IDX_HOLD];

  seq_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i   (clk_act),
    .rst_ni  (rst_ni),
    .dir_i   (dir_ctrl),
    .reg_i   (reg_ctrl),
    .count_o (count_o)
  );

  assign clr_reg_o  = flag_v[IDX_CLR];
  assign hold_reg_o = flag_v[IDX_HOLD];
endmodule

// File: rtl/seq_counter_chk.sv
module seq_counter_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_act,
  input logic             rst_ni,
  input logic             clr_dir_i,
  input logic             hold_dir_i,
  input logic             clr_set_i,
  input logic             clr_rst_i,
  input logic             hold_set_i,
  input logic             hold_rst_i,
  input logic [CNT_W-1:0] count_o,
  input logic             clr_reg_o,
  input logic             hold_reg_o
);
  // R4 R6
  clear_to_zero_chk: assert property (@(posedge clk_act) disable iff (!rst_ni)
    (clr_dir_i || clr_reg_o) |=> (count_o == '0));

  // R5
  hold_keeps_chk: assert property (@(posedge clk_act) disable iff (!rst_ni)
    (!clr_dir_i && !clr_reg_o && (hold_dir_i || hold_reg_o)) |=> $stable(count_o));

  // R2 R3
  count_step_chk: assert property (@(posedge clk_act) disable iff (!rst_ni)
    (!clr_dir_i && !clr_reg_o && !hold_dir_i && !hold_reg_o)
      |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

  // R7
  clr_flag_rst_chk: assert property (@(posedge clk_act) disable iff (!rst_ni)
    clr_rst_i |=> !clr_reg_o);

  // R7
  clr_flag_set_chk: assert property (@(posedge clk_act) disable iff (!rst_ni)
    (clr_set_i && !clr_rst_i) |=> clr_reg_o);

  // R7
  clr_flag_keep_chk: assert property (@(posedge clk_act) disable iff (!rst_ni)
    (!clr_set_i && !clr_rst_i) |=> $stable(clr_reg_o));

  // R7
  hold_flag_rst_chk: assert property (@(posedge clk_act) disable iff (!rst_ni)
    hold_rst_i |=> !hold_reg_o);

  // R7
  hold_flag_set_chk: assert property (@(posedge clk_act) disable iff (!rst_ni)
    (hold_set_i && !hold_rst_i) |=> hold_reg_o);

  // R7
  hold_flag_keep_chk: assert property (@(posedge clk_act) disable iff (!rst_ni)
    (!hold_set_i && !hold_rst_i) |=> $stable(hold_reg_o));
endmodule

bind seq_counter seq_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_act    (clk_act),
  .rst_ni     (rst_ni),
  .clr_dir_i  (clr_dir_i),
  .hold_dir_i (hold_dir_i),
  .clr_set_i  (clr_set_i),
  .clr_rst_i  (clr_rst_i),
  .hold_set_i (hold_set_i),
  .hold_rst_i (hold_rst_i),
  .count_o    (count_o),
  .clr_reg_o  (clr_reg_o),
  .hold_reg_o (hold_reg_o)
);

// File: tb/sim_seq_counter.sv
module sim_seq_counter;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       neg_edge;
  logic       clr_dir, hold_dir, clr_set, clr_rst, hold_set, hold_rst;
  logic [5:0] count;
  logic       clr_reg, hold_reg;

  int n_vec = 0;
  int n_bad = 0;
  int m_cnt = 0;
  int m_cr  = 0;
  int m_hr  = 0;

  always #4 clk = ~clk;  // 125 MHz

  seq_counter u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .neg_edge_i (neg_edge),
    .clr_dir_i  (clr_dir),
    .hold_dir_i (hold_dir),
    .clr_set_i  (clr_set),
    .clr_rst_i  (clr_rst),
    .hold_set_i (hold_set),
    .hold_rst_i (hold_rst),
    .count_o    (count),
    .clr_reg_o  (clr_reg),
    .hold_reg_o (hold_reg)
  );

  task automatic compare(input string tag);
    n_vec++;
    if (count !== 6'(m_cnt) || clr_reg !== 1'(m_cr) || hold_reg !== 1'(m_hr)) begin
      n_bad++;
      $display("FAIL %s: count=%0d clr_reg=%0b hold_reg=%0b, expected count=%0d clr_reg=%0d hold_reg=%0d",
               tag, count, clr_reg, hold_reg, m_cnt, m_cr, m_hr);
    end
  endtask

  task automatic drive(input logic cd, input logic hd, input logic cs,
                       input logic cr, input logic hs, input logic hr);
    clr_dir = cd; hold_dir = hd; clr_set = cs; clr_rst = cr; hold_set = hs; hold_rst = hr;
  endtask

  // one active edge: update model, check after it, check again after the inactive edge (R9)
  task automatic step(input string tag);
    int nc;
    if (neg_edge) @(negedge clk); else @(posedge clk);
    if (clr_dir || m_cr != 0)       nc = 0;
    else if (hold_dir || m_hr != 0) nc = m_cnt;
    else                            nc = (m_cnt + 1) % 64;
    m_cr  = clr_rst  ? 0 : (clr_set  ? 1 : m_cr);
    m_hr  = hold_rst ? 0 : (hold_set ? 1 : m_hr);
    m_cnt = nc;
    #2 compare(tag);
    #4 compare("R9");
  endtask

  task automatic idle_steps(input int n);
    drive(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      if (m_cnt == 63) step("R3"); else step("R2");
    end
  endtask

  task automatic do_reset(input logic ng);
    rst_ni = 1'b0;
    drive(0, 0, 0, 0, 0, 0);
    #1 neg_edge = ng;
    m_cnt = 0; m_cr = 0; m_hr = 0;
    #1 compare("R1");
    #13 compare("R1");
    if (ng) @(negedge clk); else @(posedge clk);
    #2 rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL R2: watchdog expired, actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    neg_edge = 1'b0;
    drive(0, 0, 0, 0, 0, 0);
    do_reset(1'b0);

    // R2 R3: free run through wrap
    idle_steps(70);

    // R5: direct hold
    drive(0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R5");
    // R4: direct clear acts on this edge (R8)
    idle_steps(4);
    drive(1, 0, 0, 0, 0, 0);
    step("R8");
    step("R4");
    // R6: direct clear with direct hold
    idle_steps(5);
    drive(1, 1, 0, 0, 0, 0);
    step("R6");

    // registered clear: latency, then clear, then release
    idle_steps(6);
    drive(0, 0, 1, 0, 0, 0);
    step("R8");            // flag set, count still advances
    drive(0, 0, 0, 0, 0, 0);
    step("R4");            // flag clears count
    step("R7");            // flag keeps, count cleared again
    drive(0, 0, 0, 1, 0, 0);
    step("R7");            // flag reset; count cleared by old flag
    idle_steps(3);

    // registered hold
    drive(0, 0, 0, 0, 1, 0);
    step("R8");
    drive(0, 0, 0, 0, 0, 0);
    step("R5");
    step("R5");
    // R6: registered hold with direct clear
    drive(1, 0, 0, 0, 0, 0);
    step("R6");
    // R7: both set and reset high, reset wins
    drive(0, 0, 0, 0, 1, 1);
    step("R7");
    drive(0, 0, 1, 1, 1, 0);
    step("R7");
    drive(0, 0, 0, 0, 0, 1);
    step("R7");
    // R6: registered clear and registered hold together
    drive(0, 0, 1, 0, 1, 0);
    step("R7");
    drive(0, 0, 0, 0, 0, 0);
    step("R6");
    drive(0, 0, 0, 1, 0, 1);
    step("R7");
    idle_steps(5);

    // R9: falling-edge mode
    do_reset(1'b1);
    idle_steps(66);
    drive(0, 1, 0, 0, 0, 0);
    step("R9");
    drive(1, 0, 0, 0, 0, 0);
    step("R9");
    drive(0, 0, 1, 0, 0, 0);
    step("R9");
    drive(0, 0, 0, 1, 0, 0);
    step("R9");
    idle_steps(4);

    // back to rising edge
    do_reset(1'b0);
    idle_steps(10);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule